// File: doc/BRIEF.md
# Power-Management Command Port with SMI Trigger

This block sits behind a byte-wide I/O command port used by system software to ask for power-management mode changes. Each byte written to the port is latched and can be read back. Two codes carry meaning for the hardware: one turns on the bit that routes power events as SCI interrupts (the ACPI mode bit of the PM1 control register), and one turns it off. Every other code passes through untouched, so firmware can still see it.

Every accepted command write can also raise a system-management interrupt. Whether it does depends on a gate bit in a configuration byte held inside the block. That byte is written through its own simple strobe. Its reset value depends on whether system-management mode is supported: without that support, the gate bit comes out of reset already set. The SMI leaves the block as a one-cycle pulse on the clock edge after the write. The mode-bit update and the SMI decision are independent, so an enable or disable command can do both in the same write.

Top module: `pm_cmd_port`

## Requirements
- R1: While and after synchronous active-high reset, cmd_rdata is 0x00, sci_en is 0, smi_pulse is 0, and cfg_rdata is 0x02 when SMM_SUPPORTED is 0 or 0x00 when it is 1.
- R2: A command write of 0xF1 makes sci_en 1 from the clock edge that accepts the write.
- R3: A command write of 0xF0 makes sci_en 0 from the clock edge that accepts the write.
- R4: A command write of any value other than 0xF0 or 0xF1 leaves sci_en unchanged.
- R5: After the edge that accepts a command write, cmd_rdata returns the written byte and keeps it until the next command write.
- R6: smi_pulse is 1 for exactly the one cycle after an accepted command write when bit 1 of the configuration byte is 1, and 0 in every other cycle. The other configuration bits have no effect on it.
- R7: The SMI gate is taken from the configuration byte held before the edge. A configuration write in the same cycle as a command write affects only later command writes.
- R8: The 0xF1 and 0xF0 commands fire the SMI under the same gate as any other code, in the same cycle as they update sci_en.
- R9: A configuration write stores the whole byte, and cfg_rdata returns it from the next cycle on.
- R10: In cycles with no write strobe, sci_en, cmd_rdata and cfg_rdata hold their values and smi_pulse is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_wdata | input | 8 | Command byte |
| cmd_rdata | output | 8 | Last command byte written |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte, bit 1 gates the SMI |
| cfg_rdata | output | 8 | Current configuration byte |
| sci_en | output | 1 | ACPI mode (SCI enable) bit of the control register |
| smi_pulse | output | 1 | One-cycle system-management interrupt request |

## Verification
A wrong mode bit shows up on sci_en one edge after the write that caused it. It stays wrong until a later enable or disable code, so a sweep of every command code from both starting states finds a bad decode within one write. A bad SMI gate or a stretched pulse shows up on smi_pulse in the very cycle after the write, or in the cycle after that. Same-cycle configuration and command writes separate a gate taken from the old byte from one taken from the new byte.

// File: rtl/pm_cmd_pkg.sv
package pm_cmd_pkg;

   // Action that a decoded command applies to the mode bit
   typedef enum logic [1:0] {
      MODE_KEEP  = 2'd0,
      MODE_SET   = 2'd1,
      MODE_CLEAR = 2'd2
   } mode_act_e;

   // Reset value of the configuration byte for a given gate position
   function automatic logic [7:0] cfg_reset_value(input bit smm_supported, input int gate_bit);
      logic [7:0] v;
      v = '0;
      if (!smm_supported) v[gate_bit] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/pm_cmd_decode.sv
module pm_cmd_decode
   import pm_cmd_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] CODE_SET   = 8'hF1,
   parameter logic [DATA_W-1:0] CODE_CLEAR = 8'hF0
) (
   input  logic              wr,
   input  logic [DATA_W-1:0] data,
   output mode_act_e         act
);

   always_comb begin
      act = MODE_KEEP;
      if (wr) begin
         if (data == CODE_SET)        act = MODE_SET;
         else if (data == CODE_CLEAR) act = MODE_CLEAR;
      end
   end

endmodule

// File: rtl/pm_mode_bit.sv
module pm_mode_bit
   import pm_cmd_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  mode_act_e act,
   output logic      mode_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= 1'b0;
      end else begin
         case (act)
            MODE_SET:   mode_q <= 1'b1;
            MODE_CLEAR: mode_q <= 1'b0;
            default:    mode_q <= mode_q;
         endcase
      end
   end

endmodule

// File: rtl/pm_byte_reg.sv
module pm_byte_reg #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)     q <= RESET_VAL;
      else if (we) q <= d;
   end

endmodule

// File: rtl/pm_smi_gen.sv
module pm_smi_gen (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   input  logic gate,
   output logic smi_q
);

   always_ff @(posedge clk) begin
      if (rst) smi_q <= 1'b0;
      else     smi_q <= fire & gate;
   end

endmodule

// File: rtl/pm_cmd_port.sv
module pm_cmd_port
   import pm_cmd_pkg::*;
#(
   parameter int                DATA_W        = 8,
   parameter logic [DATA_W-1:0] CODE_SET      = 8'hF1,
   parameter logic [DATA_W-1:0] CODE_CLEAR    = 8'hF0,
   parameter int                GATE_BIT      = 1,
   parameter bit                SMM_SUPPORTED = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic [DATA_W-1:0] cmd_rdata,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              sci_en,
   output logic              smi_pulse
);

   localparam logic [7:0]        CFG_RST8 = cfg_reset_value(SMM_SUPPORTED, GATE_BIT);
   localparam logic [DATA_W-1:0] CFG_RST  = DATA_W'(CFG_RST8);

   // Elaboration-time parameter checks
   if (DATA_W != 8) begin : g_bad_width
      $error("pm_cmd_port: DATA_W must be 8");
   end
   if (GATE_BIT < 0 || GATE_BIT >= DATA_W) begin : g_bad_gate
      $error("pm_cmd_port: GATE_BIT out of range");
   end
   if (CODE_SET == CODE_CLEAR) begin : g_bad_codes
      $error("pm_cmd_port: set and clear codes must differ");
   end

   mode_act_e act;
   logic      gate_now;

   pm_cmd_decode #(
      .DATA_W     (DATA_W),
      .CODE_SET   (CODE_SET),
      .CODE_CLEAR (CODE_CLEAR)
   ) u_decode (
      .wr   (cmd_wr),
      .data (cmd_wdata),
      .act  (act)
   );

   pm_mode_bit u_mode (
      .clk    (clk),
      .rst    (rst),
      .act    (act),
      .mode_q (sci_en)
   );

   pm_byte_reg #(
      .DATA_W    (DATA_W),
      .RESET_VAL ('0)
   ) u_cmd_reg (
      .clk (clk),
      .rst (rst),
      .we  (cmd_wr),
      .d   (cmd_wdata),
      .q   (cmd_rdata)
   );

   // Reset value of the configuration byte picked by SMM support
   if (SMM_SUPPORTED) begin : g_cfg_smm
      pm_byte_reg #(
         .DATA_W    (DATA_W),
         .RESET_VAL ('0)
      ) u_cfg_reg (
         .clk (clk),
         .rst (rst),
         .we  (cfg_wr),
         .d   (cfg_wdata),
         .q   (cfg_rdata)
      );
   end else begin : g_cfg_nosmm
      pm_byte_reg #(
         .DATA_W    (DATA_W),
         .RESET_VAL (CFG_RST)
      ) u_cfg_reg (
         .clk (clk),
         .rst (rst),
         .we  (cfg_wr),
         .d   (cfg_wdata),
         .q   (cfg_rdata)
      );
   end

   // Gate taken from the byte held before this edge
   assign gate_now = cfg_rdata[GATE_BIT];

   pm_smi_gen u_smi (
      .clk   (clk),
      .rst   (rst),
      .fire  (cmd_wr),
      .gate  (gate_now),
      .smi_q (smi_pulse)
   );

endmodule

// File: rtl/pm_cmd_port_chk.sv
module pm_cmd_port_chk #(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] CODE_SET   = 8'hF1,
   parameter logic [DATA_W-1:0] CODE_CLEAR = 8'hF0,
   parameter int                GATE_BIT   = 1
) (
   input logic              clk,
   input logic              rst,
   input logic              cmd_wr,
   input logic [DATA_W-1:0] cmd_wdata,
   input logic [DATA_W-1:0] cmd_rdata,
   input logic              cfg_wr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic [DATA_W-1:0] cfg_rdata,
   input logic              sci_en,
   input logic              smi_pulse
);

   p_sci_set_r2: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && cmd_wdata == CODE_SET) |=> sci_en);

   p_sci_clr_r3: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && cmd_wdata == CODE_CLEAR) |=> !sci_en);

   p_sci_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !(cmd_wr && (cmd_wdata == CODE_SET || cmd_wdata == CODE_CLEAR)) |=> $stable(sci_en));

   p_readback_r5: assert property (@(posedge clk) disable iff (rst)
      cmd_wr |=> (cmd_rdata == $past(cmd_wdata)));

   p_smi_fire_r6: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && cfg_rdata[GATE_BIT]) |=> smi_pulse);

   p_smi_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      !(cmd_wr && cfg_rdata[GATE_BIT]) |=> !smi_pulse);

   p_cfg_store_r9: assert property (@(posedge clk) disable iff (rst)
      cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!cmd_wr && !cfg_wr) |=> ($stable(cmd_rdata) && $stable(cfg_rdata) && !smi_pulse));

endmodule

bind pm_cmd_port pm_cmd_port_chk #(
   .DATA_W     (DATA_W),
   .CODE_SET   (CODE_SET),
   .CODE_CLEAR (CODE_CLEAR),
   .GATE_BIT   (GATE_BIT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cmd_wr    (cmd_wr),
   .cmd_wdata (cmd_wdata),
   .cmd_rdata (cmd_rdata),
   .cfg_wr    (cfg_wr),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .sci_en    (sci_en),
   .smi_pulse (smi_pulse)
);

// File: tb/pm_cmd_port_bench.sv
module pm_cmd_port_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cmd_wr = 1'b0;
   logic [7:0] cmd_wdata = '0;
   logic [7:0] cmd_rdata;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       sci_en;
   logic       smi_pulse;

   logic [7:0] s_cmd_rdata;
   logic [7:0] s_cfg_rdata;
   logic       s_sci_en;
   logic       s_smi_pulse;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pm_cmd_port u_pm_cmd_port (
      .clk       (clk),
      .rst       (rst),
      .cmd_wr    (cmd_wr),
      .cmd_wdata (cmd_wdata),
      .cmd_rdata (cmd_rdata),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .sci_en    (sci_en),
      .smi_pulse (smi_pulse)
   );

   // Second instance with SMM supported, for the other reset value
   pm_cmd_port #(.SMM_SUPPORTED(1'b1)) u_pm_cmd_port_smm (
      .clk       (clk),
      .rst       (rst),
      .cmd_wr    (1'b0),
      .cmd_wdata (8'h00),
      .cmd_rdata (s_cmd_rdata),
      .cfg_wr    (1'b0),
      .cfg_wdata (8'h00),
      .cfg_rdata (s_cfg_rdata),
      .sci_en    (s_sci_en),
      .smi_pulse (s_smi_pulse)
   );

   logic       exp_sci = 1'b0;
   logic [7:0] exp_cmd = 8'h00;
   logic [7:0] exp_cfg = 8'h02;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic next_sci(input logic cur, input logic [7:0] v);
      if (v == 8'hF1) return 1'b1;
      if (v == 8'hF0) return 1'b0;
      return cur;
   endfunction

   // One command write; returns after the accepting edge, at a falling edge
   task automatic wr_cmd(input logic [7:0] v);
      logic gate;
      gate = exp_cfg[1];
      cmd_wr    = 1'b1;
      cmd_wdata = v;
      @(negedge clk);
      cmd_wr  = 1'b0;
      exp_sci = next_sci(exp_sci, v);
      exp_cmd = v;
      chk("R2/R3/R4 sci_en", {7'd0, sci_en}, {7'd0, exp_sci});
      chk("R5 cmd_rdata", cmd_rdata, exp_cmd);
      chk("R6/R8 smi_pulse after write", {7'd0, smi_pulse}, {7'd0, gate});
      @(negedge clk);
      chk("R6 smi_pulse one cycle", {7'd0, smi_pulse}, 8'd0);
   endtask

   task automatic wr_cfg(input logic [7:0] v);
      cfg_wr    = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr  = 1'b0;
      exp_cfg = v;
      chk("R9 cfg_rdata", cfg_rdata, exp_cfg);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1 cmd_rdata in reset", cmd_rdata, 8'h00);
      chk("R1 smi in reset", {7'd0, smi_pulse}, 8'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 cmd_rdata", cmd_rdata, 8'h00);
      chk("R1 sci_en", {7'd0, sci_en}, 8'd0);
      chk("R1 smi_pulse", {7'd0, smi_pulse}, 8'd0);
      chk("R1 cfg_rdata no SMM", cfg_rdata, 8'h02);
      chk("R1 cfg_rdata with SMM", s_cfg_rdata, 8'h00);
      chk("R1 sci_en with SMM", {7'd0, s_sci_en}, 8'd0);

      // R8: enable/disable codes fire SMI with the reset gate
      wr_cmd(8'hF1);
      wr_cmd(8'hF0);

      // Sweep every code, gate on and off, from both mode states (R2 R3 R4 R6)
      for (int g = 0; g < 2; g++) begin
         wr_cfg(g != 0 ? 8'hFF : 8'hFD);
         for (int v = 0; v < 256; v++) begin
            for (int s = 0; s < 2; s++) begin
               wr_cmd(s != 0 ? 8'hF1 : 8'hF0);
               wr_cmd(8'(v));
            end
         end
      end

      // R6: only bit 1 matters
      wr_cfg(8'h02);
      wr_cmd(8'h33);
      wr_cfg(8'hFD);
      wr_cmd(8'h33);

      // R7: same-cycle config and command writes use the old gate
      wr_cfg(8'h02);
      cfg_wr = 1'b1; cfg_wdata = 8'h00;
      cmd_wr = 1'b1; cmd_wdata = 8'h5A;
      @(negedge clk);
      cfg_wr = 1'b0; cmd_wr = 1'b0;
      chk("R7 old gate on fires", {7'd0, smi_pulse}, 8'd1);
      exp_cfg = 8'h00; exp_cmd = 8'h5A;
      wr_cmd(8'h5B);
      chk("R7 new gate off", cfg_rdata, 8'h00);
      cfg_wr = 1'b1; cfg_wdata = 8'h02;
      cmd_wr = 1'b1; cmd_wdata = 8'h5C;
      @(negedge clk);
      cfg_wr = 1'b0; cmd_wr = 1'b0;
      chk("R7 old gate off silent", {7'd0, smi_pulse}, 8'd0);
      exp_cfg = 8'h02; exp_cmd = 8'h5C;
      wr_cmd(8'h5D);

      // Back-to-back writes give a pulse per write (R6)
      cmd_wr = 1'b1; cmd_wdata = 8'hF1;
      @(negedge clk);
      chk("R6 back-to-back first", {7'd0, smi_pulse}, 8'd1);
      chk("R2 back-to-back set", {7'd0, sci_en}, 8'd1);
      cmd_wdata = 8'h10;
      @(negedge clk);
      cmd_wr = 1'b0;
      chk("R6 back-to-back second", {7'd0, smi_pulse}, 8'd1);
      chk("R4 back-to-back hold", {7'd0, sci_en}, 8'd1);
      chk("R5 back-to-back readback", cmd_rdata, 8'h10);
      exp_sci = 1'b1; exp_cmd = 8'h10;

      // R9: arbitrary byte
      wr_cfg(8'hA5);

      // R10: idle cycles
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R10 idle sci_en", {7'd0, sci_en}, {7'd0, exp_sci});
         chk("R10 idle cmd_rdata", cmd_rdata, exp_cmd);
         chk("R10 idle cfg_rdata", cfg_rdata, exp_cfg);
         chk("R10 idle smi", {7'd0, smi_pulse}, 8'd0);
      end

      // R1: reset again after activity
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 re-reset cmd_rdata", cmd_rdata, 8'h00);
      chk("R1 re-reset sci_en", {7'd0, sci_en}, 8'd0);
      chk("R1 re-reset cfg_rdata", cfg_rdata, 8'h02);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule